// File: doc/BRIEF.md
# Raster Video Scan Controller

This block drives a raster display from a byte-wide video RAM. It sweeps the display area over and over without a pause. Each frame opens with a vertical blanking interval. Every scan line then starts with a horizontal blanking interval and continues with the visible pixels. During the visible part the block issues sequential byte-read addresses into video RAM and presents each returned byte as one pixel. Outside the visible part it drives a dedicated blank level that sits below the darkest visible value, and it raises the matching sync and blank flags.

Software programs four registers: the number of lines, the number of columns, the start address of the picture and a text-mode switch. A write does not disturb the frame in progress, because the block loads all four values into working copies only when a new frame begins. In text mode each byte is a character code. The block scans every text line sixteen times, once per glyph row. For each row it fetches the glyph through an external font read port and shifts the 8 glyph pixels out one per clock.

Top module: `raster_scan_ctrl`

## Requirements
- R1: A register write on `cfg_ofs` 0x0 sets the line count, 0x4 the column count, 0x8 the start address, and bit 0 at 0xC selects text mode (1) or byte-per-pixel mode (0). A write lands on the frame that starts after it and leaves the frame in progress unchanged. Reset values are 2 lines, 4 columns, start address 0x100 and byte mode.
- R2: Each frame begins with exactly V_BLANK clocks in which `vid_vsync` and `vid_blank` are 1 and `vid_hsync` is 0.
- R3: Each scan line is H_BLANK clocks with `vid_hsync` and `vid_blank` at 1, followed by exactly `columns` visible clocks in byte mode or 8×`columns` in text mode, all with `vid_blank` at 0.
- R4: In byte mode the reads run from the start address upward by one per pixel across the whole frame, in row-major order from the top-left. Video RAM returns data the cycle after `vram_rd`. The visible pixel value is {1, byte}. Outputs trail the read by three clocks.
- R5: While blanking, `vid_pix` is 9'h000. Every visible pixel has bit 8 set, so visible black is 9'h100.
- R6: In text mode the character address goes back to the start of the current text line for each of the 16 glyph rows and moves on by `columns` only after row 15. The font address is {character, row[3:0]}, and the font port answers the cycle after `font_rd`. Glyph bit 7 is shown first. A set bit shows 9'h1FF and a clear bit 9'h100.
- R7: There is no interlace. Every frame restarts at the start address and scans all lines, so frames with unchanged settings are identical.
- R8: With 0 columns every line is blanking only. With 0 lines a frame is the vertical interval alone.
- R9: While reset is held, the outputs show the blank level with `vid_vsync` and `vid_blank` at 1, `vid_hsync` at 0, and no read strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ofs | input | 4 | Register byte offset |
| cfg_wdata | input | ADDR_W | Register write data |
| vram_rd | output | 1 | Video RAM read strobe |
| vram_addr | output | ADDR_W | Video RAM byte address |
| vram_data | input | 8 | Video RAM data, one cycle after the strobe |
| font_rd | output | 1 | Font read strobe |
| font_addr | output | 12 | Font address {character, glyph row} |
| font_data | input | 8 | Glyph row bits, one cycle after the strobe |
| vid_pix | output | 9 | Pixel level |
| vid_hsync | output | 1 | Horizontal blanking flag |
| vid_vsync | output | 1 | Vertical blanking flag |
| vid_blank | output | 1 | Any blanking |

## Verification
Two things can happen in the same cycle here: a register write and the scan of the current frame, which reads the working copies of the settings. The bench provokes this by writing a new geometry and start address partway through a visible frame. It then compares every output cycle of the rest of that frame against the old settings and every cycle of the next frame against the new ones. Text mode adds a second overlap: the fetch for the next character starts while the previous glyph row is still being shifted out. The bench judges this by comparing each serialized glyph bit against a font model whose rows differ for every character.

// File: rtl/raster_pkg.sv
// Package: shared types and constants for the raster scan controller.
// Assumes glyphs are 8 pixels wide and 16 rows high.
package raster_pkg;

    localparam int OFS_W       = 4;
    localparam int GLYPH_ROWS  = 16;
    localparam int ROW_W       = $clog2(GLYPH_ROWS);
    localparam int PIX_W       = 9;

    localparam logic [OFS_W-1:0] OFS_LINES  = 4'h0;
    localparam logic [OFS_W-1:0] OFS_COLS   = 4'h4;
    localparam logic [OFS_W-1:0] OFS_ORIGIN = 4'h8;
    localparam logic [OFS_W-1:0] OFS_MODE   = 4'hC;

    localparam logic [PIX_W-1:0] BLANK_LVL = 9'h000;
    localparam logic [PIX_W-1:0] GLYPH_ON  = 9'h1FF;
    localparam logic [PIX_W-1:0] GLYPH_OFF = 9'h100;

    typedef enum logic [1:0] {
        ST_VBLANK = 2'd0,
        ST_HBLANK = 2'd1,
        ST_ACTIVE = 2'd2
    } scan_state_e;

    // Per-clock scan information travelling down the pixel pipeline
    typedef struct packed {
        logic             vb;
        logic             hb;
        logic             act;
        logic             text;
        logic [2:0]       bitx;
        logic [ROW_W-1:0] row;
    } tap_t;

endpackage

// File: rtl/raster_cfg.sv
// Module: programmable registers plus the working copies used by the scan.
// Live registers take writes at any time. The working copies load only on
// the frame-start pulse, so a frame always runs from one consistent set.
module raster_cfg
    import raster_pkg::*;
#(
    parameter int                DIM_W     = 12,
    parameter int                ADDR_W    = 20,
    parameter logic [DIM_W-1:0]  LINES_RST = 2,
    parameter logic [DIM_W-1:0]  COLS_RST  = 4,
    parameter logic [ADDR_W-1:0] ORG_RST   = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              load,
    output logic [DIM_W-1:0]  sh_lines,
    output logic [DIM_W-1:0]  sh_cols,
    output logic [ADDR_W-1:0] sh_org,
    output logic              sh_text
);

    logic [DIM_W-1:0]  lv_lines;
    logic [DIM_W-1:0]  lv_cols;
    logic [ADDR_W-1:0] lv_org;
    logic              lv_text;

    // Decode register writes into the live copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lv_lines <= LINES_RST;
            lv_cols  <= COLS_RST;
            lv_org   <= ORG_RST;
            lv_text  <= 1'b0;
        end else if (we) begin
            case (ofs)
                OFS_LINES:  lv_lines <= wdata[DIM_W-1:0];
                OFS_COLS:   lv_cols  <= wdata[DIM_W-1:0];
                OFS_ORIGIN: lv_org   <= wdata;
                OFS_MODE:   lv_text  <= wdata[0];
                default:    ;
            endcase
        end
    end

    // Copy the live values into the working set at each frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_lines <= LINES_RST;
            sh_cols  <= COLS_RST;
            sh_org   <= ORG_RST;
            sh_text  <= 1'b0;
        end else if (load) begin
            sh_lines <= lv_lines;
            sh_cols  <= lv_cols;
            sh_org   <= lv_org;
            sh_text  <= lv_text;
        end
    end

endmodule

// File: rtl/raster_timing.sv
// Module: frame and line sequencer with the fetch address generator.
// One scan step per clock. In text mode each character takes 8 steps and
// each text line repeats for all glyph rows. Assumes H_BLANK, V_BLANK >= 1.
module raster_timing
    import raster_pkg::*;
#(
    parameter int DIM_W   = 12,
    parameter int ADDR_W  = 20,
    parameter int H_BLANK = 4,
    parameter int V_BLANK = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIM_W-1:0]  sh_lines,
    input  logic [DIM_W-1:0]  sh_cols,
    input  logic [ADDR_W-1:0] sh_org,
    input  logic              sh_text,
    output logic              frame_load,
    output logic              scan_rd,
    output logic [ADDR_W-1:0] scan_addr,
    output tap_t              tap
);

    localparam int CNT_MAX = (H_BLANK > V_BLANK) ? H_BLANK : V_BLANK;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] H_LAST = CNT_W'(H_BLANK - 1);
    localparam logic [CNT_W-1:0] V_LAST = CNT_W'(V_BLANK - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(GLYPH_ROWS - 1);

    scan_state_e       st;
    logic [CNT_W-1:0]  cnt;
    logic [DIM_W-1:0]  col;
    logic [DIM_W-1:0]  line;
    logic [2:0]        bitc;
    logic [ROW_W-1:0]  row;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] base;

    logic [DIM_W-1:0]  cols_last;
    logic [DIM_W-1:0]  lines_last;
    logic              char_end;
    logic              hb_done;
    logic              vb_done;
    logic              line_done;
    logic              last_row;
    logic              frame_done;

    // Derive the end-of-character, end-of-line and end-of-frame events
    always_comb begin
        cols_last  = sh_cols - 1'b1;
        lines_last = sh_lines - 1'b1;
        char_end   = !sh_text || (bitc == 3'd7);
        hb_done    = (st == ST_HBLANK) && (cnt == H_LAST);
        vb_done    = (st == ST_VBLANK) && (cnt == V_LAST);
        line_done  = ((st == ST_ACTIVE) && char_end && (col == cols_last))
                   || (hb_done && (sh_cols == '0));
        last_row   = !sh_text || (row == ROW_LAST);
        frame_done = line_done && last_row && (line == lines_last);
        frame_load = frame_done || (vb_done && (sh_lines == '0));
        scan_rd    = (st == ST_ACTIVE) && (!sh_text || (bitc == 3'd0));
        scan_addr  = addr;
        tap.vb     = (st == ST_VBLANK);
        tap.hb     = (st == ST_HBLANK);
        tap.act    = (st == ST_ACTIVE);
        tap.text   = sh_text;
        tap.bitx   = bitc;
        tap.row    = row;
    end

    // Advance the state, the counters and the fetch address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_VBLANK;
            cnt  <= '0;
            col  <= '0;
            line <= '0;
            bitc <= '0;
            row  <= '0;
            addr <= '0;
            base <= '0;
        end else begin
            case (st)
                ST_VBLANK: begin
                    cnt <= cnt + 1'b1;
                    if (vb_done) begin
                        cnt  <= '0;
                        line <= '0;
                        row  <= '0;
                        addr <= sh_org;
                        base <= sh_org;
                        if (sh_lines != '0) st <= ST_HBLANK;
                    end
                end
                ST_HBLANK: begin
                    cnt <= cnt + 1'b1;
                    if (hb_done) begin
                        cnt  <= '0;
                        col  <= '0;
                        bitc <= '0;
                        if (sh_cols != '0) st <= ST_ACTIVE;
                    end
                end
                ST_ACTIVE: begin
                    if (char_end) begin
                        col  <= col + 1'b1;
                        addr <= addr + 1'b1;
                    end
                    bitc <= sh_text ? bitc + 1'b1 : 3'd0;
                end
                default: st <= ST_VBLANK;
            endcase
            if (frame_done) begin
                st  <= ST_VBLANK;
                cnt <= '0;
            end else if (line_done) begin
                st  <= ST_HBLANK;
                cnt <= '0;
                if (last_row) begin
                    row  <= '0;
                    line <= line + 1'b1;
                    base <= base + ADDR_W'(sh_cols);
                    addr <= base + ADDR_W'(sh_cols);
                end else begin
                    row  <= row + 1'b1;
                    addr <= base;
                end
            end
        end
    end

endmodule

// File: rtl/raster_pixel.sv
// Module: three-stage pixel pipeline. Stage 1 waits for the video byte and
// issues the font read. Stage 2 picks the byte or the glyph bit. Stage 3
// registers the outputs. Assumes both memories answer one cycle after a read.
module raster_pixel
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  tap_t              tap,
    input  logic [7:0]        vram_data,
    input  logic [7:0]        font_data,
    output logic              font_rd,
    output logic [11:0]       font_addr,
    output logic [PIX_W-1:0]  vid_pix,
    output logic              vid_hsync,
    output logic              vid_vsync,
    output logic              vid_blank
);

    tap_t       t1;
    logic       t2_act;
    logic       t2_text;
    logic       t2_hb;
    logic       t2_vb;
    logic [2:0] t2_bit;
    logic [7:0] byte_q;
    logic [7:0] glyph_q;
    logic [7:0] glyph_sel;
    logic       glyph_bit;

    // Issue the glyph lookup while the character byte is on the bus
    always_comb begin
        font_rd   = t1.act && t1.text && (t1.bitx == 3'd0);
        font_addr = {vram_data, t1.row};
    end

    // Stages 1 and 2: carry the scan info and capture the fetched byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t1      <= '{vb: 1'b1, default: '0};
            t2_act  <= 1'b0;
            t2_text <= 1'b0;
            t2_hb   <= 1'b0;
            t2_vb   <= 1'b1;
            t2_bit  <= '0;
            byte_q  <= '0;
        end else begin
            t1      <= tap;
            t2_act  <= t1.act;
            t2_text <= t1.text;
            t2_hb   <= t1.hb;
            t2_vb   <= t1.vb;
            t2_bit  <= t1.bitx;
            if (t1.act && !t1.text) byte_q <= vram_data;
        end
    end

    // Hold the glyph row for the seven pixels after its arrival
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glyph_q <= '0;
        end else if (t2_act && t2_text && (t2_bit == 3'd0)) begin
            glyph_q <= font_data;
        end
    end

    // Pick the current glyph bit, most significant first
    always_comb begin
        glyph_sel = (t2_bit == 3'd0) ? font_data : glyph_q;
        glyph_bit = glyph_sel[3'd7 - t2_bit];
    end

    // Stage 3: register the video outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_pix   <= BLANK_LVL;
            vid_hsync <= 1'b0;
            vid_vsync <= 1'b1;
            vid_blank <= 1'b1;
        end else begin
            if (!t2_act)      vid_pix <= BLANK_LVL;
            else if (t2_text) vid_pix <= glyph_bit ? GLYPH_ON : GLYPH_OFF;
            else              vid_pix <= {1'b1, byte_q};
            vid_hsync <= t2_hb;
            vid_vsync <= t2_vb;
            vid_blank <= !t2_act;
        end
    end

endmodule

// File: rtl/raster_scan_ctrl.sv
// Module: top of the raster scan controller. It ties the register set, the
// sequencer and the pixel pipeline together. Outputs trail the scan by three
// clocks. Both memory ports are plain synchronous reads with no back-pressure.
module raster_scan_ctrl
    import raster_pkg::*;
#(
    parameter int                DIM_W     = 12,
    parameter int                ADDR_W    = 20,
    parameter int                H_BLANK   = 4,
    parameter int                V_BLANK   = 6,
    parameter logic [DIM_W-1:0]  LINES_RST = 2,
    parameter logic [DIM_W-1:0]  COLS_RST  = 4,
    parameter logic [ADDR_W-1:0] ORG_RST   = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_ofs,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              vram_rd,
    output logic [ADDR_W-1:0] vram_addr,
    input  logic [7:0]        vram_data,
    output logic              font_rd,
    output logic [11:0]       font_addr,
    input  logic [7:0]        font_data,
    output logic [8:0]        vid_pix,
    output logic              vid_hsync,
    output logic              vid_vsync,
    output logic              vid_blank
);

    logic [DIM_W-1:0]  sh_lines;
    logic [DIM_W-1:0]  sh_cols;
    logic [ADDR_W-1:0] sh_org;
    logic              sh_text;
    logic              frame_load;
    tap_t              tap;

    raster_cfg #(
        .DIM_W(DIM_W), .ADDR_W(ADDR_W),
        .LINES_RST(LINES_RST), .COLS_RST(COLS_RST), .ORG_RST(ORG_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .ofs(cfg_ofs), .wdata(cfg_wdata),
        .load(frame_load), .sh_lines(sh_lines), .sh_cols(sh_cols),
        .sh_org(sh_org), .sh_text(sh_text)
    );

    raster_timing #(
        .DIM_W(DIM_W), .ADDR_W(ADDR_W), .H_BLANK(H_BLANK), .V_BLANK(V_BLANK)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .sh_lines(sh_lines), .sh_cols(sh_cols),
        .sh_org(sh_org), .sh_text(sh_text), .frame_load(frame_load),
        .scan_rd(vram_rd), .scan_addr(vram_addr), .tap(tap)
    );

    raster_pixel u_pixel (
        .clk(clk), .rst_n(rst_n), .tap(tap), .vram_data(vram_data),
        .font_data(font_data), .font_rd(font_rd), .font_addr(font_addr),
        .vid_pix(vid_pix), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync),
        .vid_blank(vid_blank)
    );

endmodule

// File: rtl/raster_scan_ctrl_sva.sv
// Module: property checker for the raster scan controller. It is attached to
// every instance through the bind below and only observes top-level ports.
module raster_scan_ctrl_sva #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vram_rd,
    input logic [ADDR_W-1:0] vram_addr,
    input logic              font_rd,
    input logic [8:0]        vid_pix,
    input logic              vid_hsync,
    input logic              vid_vsync,
    input logic              vid_blank
);

    // R2: the two sync flags never overlap
    a_r2_sync_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(vid_hsync && vid_vsync));

    // R3: either sync interval is always a blanked interval
    a_r3_sync_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_hsync || vid_vsync) |-> vid_blank);

    // R5: blanking carries the blank level
    a_r5_blank_level: assert property (@(posedge clk) disable iff (!rst_n)
        vid_blank |-> (vid_pix == 9'h000));

    // R5: visible pixels sit above the blank level
    a_r5_visible_marker: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_blank |-> vid_pix[8]);

    // R4: back-to-back reads step the address by one
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_rd && $past(vram_rd)) |-> (vram_addr == $past(vram_addr) + 1'b1));

    // R6: a glyph lookup always follows a character fetch
    a_r6_font_after_char: assert property (@(posedge clk) disable iff (!rst_n)
        font_rd |-> $past(vram_rd));

endmodule

bind raster_scan_ctrl raster_scan_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .vram_rd(vram_rd), .vram_addr(vram_addr),
    .font_rd(font_rd), .vid_pix(vid_pix), .vid_hsync(vid_hsync),
    .vid_vsync(vid_vsync), .vid_blank(vid_blank)
);

// File: tb/raster_scan_ctrl_bench.sv
// Bench: directed scenarios that compare every output cycle of whole frames
// against a reference stream built from the requirements.
module raster_scan_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HB = 4;
    localparam int VB = 6;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_ofs = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          vram_rd;
    logic [AW-1:0] vram_addr;
    logic [7:0]    vram_data = '0;
    logic          font_rd;
    logic [11:0]   font_addr;
    logic [7:0]    font_data = '0;
    logic [8:0]    vid_pix;
    logic          vid_hsync;
    logic          vid_vsync;
    logic          vid_blank;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_scan_ctrl #(.ADDR_W(AW), .H_BLANK(HB), .V_BLANK(VB)) u_raster_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ofs(cfg_ofs),
        .cfg_wdata(cfg_wdata), .vram_rd(vram_rd), .vram_addr(vram_addr),
        .vram_data(vram_data), .font_rd(font_rd), .font_addr(font_addr),
        .font_data(font_data), .vid_pix(vid_pix), .vid_hsync(vid_hsync),
        .vid_vsync(vid_vsync), .vid_blank(vid_blank)
    );

    function automatic logic [7:0] vramf(input logic [AW-1:0] a);
        return 8'(a * 37 + (a >> 8) + 5);
    endfunction

    function automatic logic [7:0] fontf(input logic [11:0] f);
        return 8'((f[11:4] ^ (8'(f[3:0]) * 8'h1D)) + 8'h03);
    endfunction

    // Memory models: data the cycle after the strobe
    always @(posedge clk) begin
        if (vram_rd) vram_data <= vramf(vram_addr);
        if (font_rd) font_data <= fontf(font_addr);
    end

    task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got blank/vs/hs/pix %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the current cycle, then step to the next sample point
    task automatic expect_step(input logic [11:0] exp, input string tag);
        chk({vid_blank, vid_vsync, vid_hsync, vid_pix}, exp, tag);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] ofs, input logic [AW-1:0] d);
        cfg_we = 1'b1; cfg_ofs = ofs; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int l, input int c, input logic [AW-1:0] org, input logic txt);
        wr(4'h0, AW'(l));
        wr(4'h4, AW'(c));
        wr(4'h8, org);
        wr(4'hC, AW'(txt));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Wait until the outputs enter a new vertical interval
    task automatic align();
        logic prev;
        bit   hit;
        prev = vid_vsync;
        hit  = 1'b0;
        while (!hit) begin
            @(negedge clk);
            hit  = vid_vsync && !prev;
            prev = vid_vsync;
        end
    endtask

    // Reference stream for one complete frame
    task automatic run_frame(input int l, input int c, input logic [AW-1:0] org,
                             input logic txt, input string tag);
        int rows;
        int per;
        rows = txt ? 16 : 1;
        per  = txt ? 8 : 1;
        for (int v = 0; v < VB; v++) expect_step({3'b110, 9'h000}, {tag, " R2 R5 vertical"});
        for (int ln = 0; ln < l; ln++) begin
            for (int r = 0; r < rows; r++) begin
                for (int h = 0; h < HB; h++) expect_step({3'b101, 9'h000}, {tag, " R3 R5 horizontal"});
                for (int cc = 0; cc < c; cc++) begin
                    for (int b = 0; b < per; b++) begin
                        logic [AW-1:0] a;
                        logic [7:0]    ch;
                        logic [7:0]    g;
                        a = org + AW'(ln * c + cc);
                        ch = vramf(a);
                        if (txt) begin
                            g = fontf({ch, 4'(r)});
                            expect_step({3'b000, g[7-b] ? 9'h1FF : 9'h100}, {tag, " R6 glyph"});
                        end else begin
                            expect_step({3'b000, 1'b1, ch}, {tag, " R4 byte"});
                        end
                    end
                end
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({vid_blank, vid_vsync, vid_hsync, vid_pix}, {3'b110, 9'h000}, "R9 reset outputs");
        chk({10'd0, vram_rd, font_rd}, 12'd0, "R9 reset strobes");
        rst_n = 1'b1;
    endtask

    task automatic t_pixel();
        do_reset();
        setup(3, 5, 20'h00100, 1'b0);
        align();
        run_frame(3, 5, 20'h00100, 1'b0, "R1 R4 pixel frame");
        run_frame(3, 5, 20'h00100, 1'b0, "R7 repeat frame");
    endtask

    task automatic t_origin();
        do_reset();
        setup(2, 3, 20'h001F3, 1'b0);
        align();
        run_frame(2, 3, 20'h001F3, 1'b0, "R1 R4 moved origin");
    endtask

    task automatic t_text();
        do_reset();
        setup(2, 3, 20'h00140, 1'b1);
        align();
        run_frame(2, 3, 20'h00140, 1'b1, "R6 text frame");
        run_frame(2, 3, 20'h00140, 1'b1, "R7 text repeat");
    endtask

    task automatic t_zero();
        do_reset();
        setup(2, 0, 20'h00100, 1'b0);
        align();
        run_frame(2, 0, 20'h00100, 1'b0, "R8 zero columns");
        do_reset();
        setup(0, 4, 20'h00100, 1'b0);
        align();
        run_frame(0, 4, 20'h00100, 1'b0, "R8 zero lines");
        run_frame(0, 4, 20'h00100, 1'b0, "R8 zero lines again");
    endtask

    task automatic t_defer();
        do_reset();
        setup(3, 5, 20'h00100, 1'b0);
        align();
        fork
            run_frame(3, 5, 20'h00100, 1'b0, "R1 old settings kept");
            begin
                repeat (10) @(negedge clk);
                setup(2, 2, 20'h00180, 1'b0);
            end
        join
        run_frame(2, 2, 20'h00180, 1'b0, "R1 new settings applied");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_pixel();
        t_origin();
        t_text();
        t_zero();
        t_defer();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

endmodule